// File: doc/BRIEF.md
# Circular Trace Memory Sink

This block takes 32-bit trace words from a producer over a valid/ready handshake and stores each one into a circular window of system memory. The window is given by a start address and a limit address. The limit address is the address of the last word slot, not one byte past the end. A 64-bit write pointer names the slot for the next word. After every word that memory accepts, the pointer moves forward by the word width of 4 bytes. When the word just stored sat at or beyond the limit, the pointer goes back to the start instead. A sticky wrap flag then records that older data has been overwritten.

Software sees the block through a 32-bit register port. Each 64-bit address is split into a low half and a high half. The wrap flag is carried in bit 0 of the write-pointer low register, so software clears that bit to get the real address. Start and limit values are trimmed to a 2^ALIGN_LOG2 byte boundary, and software reads them back to learn what was kept.

The usual sequence is: program start and limit, set the write pointer to the start, then set the enable bit. Once the buffer has wrapped, the oldest data runs from the write pointer up to the limit plus 4 bytes. The newer data runs from the start up to the write pointer.

Top module: `trace_ring_sink`

## Requirements
- R1: After reset every register reads zero, the wrap flag is clear, `mem_valid` is low and `trc_ready` is low.
- R2: Register offsets are fixed. Control is at 0x00, with bit 0 as the enable bit. Start low/high are at 0x10/0x14, limit low/high at 0x18/0x1C, and write pointer low/high at 0x20/0x24. Start and limit keep the 32 bits written to each half, except that the address bits below ALIGN_LOG2 (default 2) are stored and read as zero.
- R3: A write to offset 0x20 or 0x24 loads that half of the write pointer. Address bits [1:0] are trimmed to zero. Bit 0 of a write to offset 0x20 loads the wrap flag, so writing 0 clears it. Offset 0x20 reads back as pointer bits [31:1] with the wrap flag in bit 0.
- R4: While the block is enabled, a trace word is presented on the memory port. `mem_addr` equals the write pointer and `mem_data` equals the trace word. Each accepted memory write that lands below the limit advances the pointer by 4.
- R5: An accepted write whose address is at or above the limit sends the pointer back to the start address and sets the wrap flag. The flag stays set until software clears it.
- R6: While `mem_ready` is low, `trc_ready` is low. A pending write keeps the same address and the same data, and the pointer does not move, so no word is lost.
- R7: While the block is disabled, `trc_valid` has no effect: `mem_valid` and `trc_ready` stay low and the pointer does not change.
- R8: Clearing the enable bit while a memory write is stalled keeps `mem_valid` high until that write is accepted. After that, no further words are taken.
- R9: The read-pointer offsets 0x28 and 0x2C, and every unmapped offset, read zero. Writes to them change nothing.
- R10: When the limit equals the start, every word is written to the start address and the wrap flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| trc_valid | input | 1 | Trace word valid |
| trc_ready | output | 1 | Trace word accepted this cycle |
| trc_data | input | DATA_W | Trace word |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | ADDR_W | Memory write byte address |
| mem_data | output | DATA_W | Memory write data |

## Verification
A wrong pointer or limit compare shows on `mem_addr` at the very next accepted write. The bench checks the address of every handshake against its own model of the pointer, so a bad step, a late return to the start or a missed wrap is reported in the cycle it happens. A wrap flag that is set at the wrong time, or not at all, only shows when offset 0x20 is read. For that reason the bench reads it back after each stream, after a clear and after the single-slot case. An enable that drops too early shows as `mem_valid` falling while a write is still stalled, and the bench catches that within one cycle.

// File: rtl/trace_ring_sink.sv
module trace_ring_sink #(
  parameter int ADDR_W     = 64,
  parameter int DATA_W     = 32,
  parameter int ALIGN_LOG2 = 2,
  parameter int REG_AW     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              trc_valid,
  output logic              trc_ready,
  input  logic [DATA_W-1:0] trc_data,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data
);
  localparam int STEP      = DATA_W / 8;
  localparam int WORD_LOG2 = $clog2(STEP);
  localparam int HI_W      = ADDR_W - 32;
  localparam logic [ADDR_W-1:0] CFG_MASK  = ~((ADDR_W'(1) << ALIGN_LOG2) - ADDR_W'(1));
  localparam logic [ADDR_W-1:0] WORD_MASK = ~((ADDR_W'(1) << WORD_LOG2) - ADDR_W'(1));
  localparam logic [REG_AW-1:0] OFF_CTRL  = REG_AW'('h00);
  localparam logic [REG_AW-1:0] OFF_ST_LO = REG_AW'('h10);
  localparam logic [REG_AW-1:0] OFF_ST_HI = REG_AW'('h14);
  localparam logic [REG_AW-1:0] OFF_LM_LO = REG_AW'('h18);
  localparam logic [REG_AW-1:0] OFF_LM_HI = REG_AW'('h1C);
  localparam logic [REG_AW-1:0] OFF_WP_LO = REG_AW'('h20);
  localparam logic [REG_AW-1:0] OFF_WP_HI = REG_AW'('h24);

  logic              en_req, en_act, wrap_q;
  logic [ADDR_W-1:0] start_q, limit_q, wp_q;

  wire sel_ctrl  = reg_we && (reg_addr == OFF_CTRL);
  wire sel_st_lo = reg_we && (reg_addr == OFF_ST_LO);
  wire sel_st_hi = reg_we && (reg_addr == OFF_ST_HI);
  wire sel_lm_lo = reg_we && (reg_addr == OFF_LM_LO);
  wire sel_lm_hi = reg_we && (reg_addr == OFF_LM_HI);
  wire sel_wp_lo = reg_we && (reg_addr == OFF_WP_LO);
  wire sel_wp_hi = reg_we && (reg_addr == OFF_WP_HI);

  wire en_nxt    = sel_ctrl ? reg_wdata[0] : en_req;
  wire in_flight = mem_valid && !mem_ready;
  wire fire      = mem_valid && mem_ready;
  wire at_limit  = wp_q >= limit_q;

  assign mem_valid = en_act && trc_valid;
  assign trc_ready = en_act && mem_ready;
  assign mem_addr  = wp_q;
  assign mem_data  = trc_data;

  function automatic logic [ADDR_W-1:0] put_lo(input logic [ADDR_W-1:0] old, input logic [31:0] v);
    return {old[ADDR_W-1:32], v};
  endfunction

  function automatic logic [ADDR_W-1:0] put_hi(input logic [ADDR_W-1:0] old, input logic [31:0] v);
    return {v[HI_W-1:0], old[31:0]};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_req  <= 1'b0;
      en_act  <= 1'b0;
      wrap_q  <= 1'b0;
      start_q <= '0;
      limit_q <= '0;
      wp_q    <= '0;
    end else begin
      en_req <= en_nxt;
      if (!in_flight) en_act <= en_nxt;
      if (sel_st_lo) start_q <= put_lo(start_q, reg_wdata) & CFG_MASK;
      if (sel_st_hi) start_q <= put_hi(start_q, reg_wdata) & CFG_MASK;
      if (sel_lm_lo) limit_q <= put_lo(limit_q, reg_wdata) & CFG_MASK;
      if (sel_lm_hi) limit_q <= put_hi(limit_q, reg_wdata) & CFG_MASK;
      if (sel_wp_lo)      wp_q <= put_lo(wp_q, reg_wdata) & WORD_MASK;
      else if (sel_wp_hi) wp_q <= put_hi(wp_q, reg_wdata) & WORD_MASK;
      else if (fire)      wp_q <= at_limit ? start_q : wp_q + ADDR_W'(STEP);
      if (sel_wp_lo)              wrap_q <= reg_wdata[0];
      else if (fire && at_limit)  wrap_q <= 1'b1;
    end
  end

  always_comb begin
    case (reg_addr)
      OFF_CTRL:  reg_rdata = {31'b0, en_req};
      OFF_ST_LO: reg_rdata = start_q[31:0];
      OFF_ST_HI: reg_rdata = 32'(start_q[ADDR_W-1:32]);
      OFF_LM_LO: reg_rdata = limit_q[31:0];
      OFF_LM_HI: reg_rdata = 32'(limit_q[ADDR_W-1:32]);
      OFF_WP_LO: reg_rdata = {wp_q[31:1], wrap_q};
      OFF_WP_HI: reg_rdata = 32'(wp_q[ADDR_W-1:32]);
      default:   reg_rdata = '0;
    endcase
  end

  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !at_limit && !reg_we) |=> (wp_q == $past(wp_q) + ADDR_W'(STEP)));

  // R5
  wrap_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && at_limit && !reg_we) |=> (wp_q == $past(start_q) && wrap_q));

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_flight && !reg_we) |=> $stable(wp_q));

  // R7
  idle_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_act && !reg_we) |=> $stable(wp_q));

  // R8
  drain_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_flight |=> mem_valid);
endmodule

// File: tb/trace_ring_sink_tb.sv
`timescale 1ns/1ps
module trace_ring_sink_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        trc_valid = 1'b0;
  logic        trc_ready;
  logic [31:0] trc_data = '0;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic [63:0] mem_addr;
  logic [31:0] mem_data;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [63:0] m_start, m_limit, m_wp;
  logic        m_wrap;
  logic [31:0] rd;

  trace_ring_sink u_dut (.*);

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog act=%0d exp=<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] trim(input logic [63:0] a);
    return a & ~64'h3;
  endfunction

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rdr(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic setup(input logic [63:0] s, input logic [63:0] l);
    wr(6'h10, s[31:0]); wr(6'h14, s[63:32]);
    wr(6'h18, l[31:0]); wr(6'h1C, l[63:32]);
    m_start = trim(s); m_limit = trim(l);
    wr(6'h20, m_start[31:0]); wr(6'h24, m_start[63:32]);
    m_wp = m_start; m_wrap = 1'b0;
  endtask

  task automatic model_step();
    if (m_wp >= m_limit) begin m_wp = m_start; m_wrap = 1'b1; end
    else m_wp = m_wp + 64'd4;
  endtask

  task automatic stream(input int n, input int ready_pct);
    int sent = 0;
    bit pend = 0;
    while (sent < n) begin
      @(negedge clk);
      if (!pend) begin trc_valid = ($urandom % 4) != 0; trc_data = $urandom; end
      mem_ready = int'($urandom % 100) < ready_pct;
      #1;
      if (trc_valid) begin
        chk(mem_addr == m_wp, "R4/R5 address", mem_addr, m_wp);
        if (mem_ready) begin
          chk(trc_ready && mem_data == trc_data, "R4 data", {32'b0, mem_data}, {32'b0, trc_data});
          model_step();
          sent++; pend = 0;
        end else begin
          chk(!trc_ready && mem_valid, "R6 stall", {63'b0, trc_ready}, 64'd0);
          pend = 1;
        end
      end
    end
    @(negedge clk); trc_valid = 1'b0; mem_ready = 1'b0;
  endtask

  task automatic check_wp(input string req);
    rdr(6'h20, rd);
    chk(rd == (m_wp[31:0] | {31'b0, m_wrap}), req, {32'b0, rd}, {32'b0, m_wp[31:0] | {31'b0, m_wrap}});
    rdr(6'h24, rd);
    chk(rd == m_wp[63:32], req, {32'b0, rd}, {32'b0, m_wp[63:32]});
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    trc_valid = 1'b1;
    // R1 reset state
    for (int a = 0; a < 64; a += 4) begin
      rdr(6'(a), rd);
      chk(rd == 32'd0, "R1 reset register", {32'b0, rd}, 64'd0);
    end
    chk(!mem_valid && !trc_ready, "R1 R7 idle outputs", {62'b0, mem_valid, trc_ready}, 64'd0);
    trc_valid = 1'b0;

    // R2 trimming and readback
    wr(6'h10, 32'h0000_1003); wr(6'h14, 32'h0000_0001);
    wr(6'h18, 32'h0000_103F); wr(6'h1C, 32'h0000_0001);
    rdr(6'h10, rd); chk(rd == 32'h1000, "R2 start low", {32'b0, rd}, 64'h1000);
    rdr(6'h14, rd); chk(rd == 32'h1, "R2 start high", {32'b0, rd}, 64'h1);
    rdr(6'h18, rd); chk(rd == 32'h103C, "R2 limit low", {32'b0, rd}, 64'h103C);
    rdr(6'h1C, rd); chk(rd == 32'h1, "R2 limit high", {32'b0, rd}, 64'h1);

    // R9 read pointer and unmapped offsets
    wr(6'h28, 32'hFFFF_FFFF); wr(6'h2C, 32'hFFFF_FFFF); wr(6'h30, 32'hFFFF_FFFF);
    rdr(6'h28, rd); chk(rd == 0, "R9 rp low", {32'b0, rd}, 0);
    rdr(6'h2C, rd); chk(rd == 0, "R9 rp high", {32'b0, rd}, 0);
    rdr(6'h30, rd); chk(rd == 0, "R9 unmapped", {32'b0, rd}, 0);
    rdr(6'h10, rd); chk(rd == 32'h1000, "R9 start untouched", {32'b0, rd}, 64'h1000);

    // R3 write pointer load, trim and wrap flag
    wr(6'h20, 32'h0000_1003);
    rdr(6'h20, rd); chk(rd == 32'h1001, "R3 wp low with flag", {32'b0, rd}, 64'h1001);
    wr(6'h20, 32'h0000_1000);
    rdr(6'h20, rd); chk(rd == 32'h1000, "R3 flag cleared", {32'b0, rd}, 64'h1000);

    setup(64'h1_0000_1000, 64'h1_0000_103C);

    // R7 disabled ignores trace
    trc_valid = 1'b1; mem_ready = 1'b1;
    repeat (3) begin
      @(negedge clk); #1;
      chk(!mem_valid && !trc_ready, "R7 disabled", {62'b0, mem_valid, trc_ready}, 0);
    end
    trc_valid = 1'b0; mem_ready = 1'b0;
    check_wp("R7 pointer unchanged");

    // R4 R5 R6 stream with wraps
    wr(6'h00, 32'h1);
    stream(200, 65);
    check_wp("R5 wrap flag after stream");

    // R3 clearing the flag
    wr(6'h20, m_wp[31:0]); m_wrap = 1'b0;
    check_wp("R3 flag clear");

    // R10 single slot
    wr(6'h00, 32'h0);
    setup(64'h0000_0000_0000_2000, 64'h0000_0000_0000_2000);
    wr(6'h00, 32'h1);
    stream(12, 80);
    chk(m_wrap, "R10 model wrap", {63'b0, m_wrap}, 1);
    check_wp("R10 single slot pointer");

    // random configurations
    for (int k = 0; k < 4; k++) begin
      logic [63:0] s, l;
      wr(6'h00, 32'h0);
      s = {$urandom % 16, $urandom};
      l = trim(s) + 64'(4 * (1 + $urandom % 10)) + 64'($urandom % 4);
      setup(s, l);
      wr(6'h00, 32'h1);
      stream(60, 50 + 10 * k);
      check_wp("R5 random config pointer");
    end

    // R8 disable while stalled
    @(negedge clk); trc_valid = 1'b1; trc_data = 32'hCAFE_0001; mem_ready = 1'b0;
    wr(6'h00, 32'h0);
    #1 chk(mem_valid && mem_addr == m_wp, "R8 pending kept", mem_addr, m_wp);
    @(negedge clk); mem_ready = 1'b1; #1;
    chk(mem_valid && mem_addr == m_wp, "R8 pending fires", {63'b0, mem_valid}, 1);
    model_step();
    repeat (2) begin
      @(negedge clk); #1;
      chk(!mem_valid && !trc_ready, "R8 no further words", {62'b0, mem_valid, trc_ready}, 0);
    end
    trc_valid = 1'b0; mem_ready = 1'b0;
    check_wp("R8 single advance");
    rdr(6'h00, rd); chk(rd == 0, "R2 control readback", {32'b0, rd}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule